// File: doc/BRIEF.md
# Self-Calibrating Dual-Slope DAC Controller

This block sequences an integrating digital-to-analog converter whose integrator gain is digitally trimmable. After reset it runs a calibration loop. Each pass clears the integrator, lets it integrate the reference for a fixed window of 2^N clocks, and then freezes it. It waits for a comparator decision to cross a two-flop synchronizer and then moves a gain code one step toward balance. The loop ends when the trim direction has flipped on two passes in a row, or when a pass limit is reached. The gain is then held.

When calibration ends, the controller sits in a frozen hold state. A code presented with its valid strobe in that state starts a conversion. The controller pulses the integrator clear and integrates the reference for a number of clocks proportional to the code. It then raises freeze again, so the integrator itself holds the result and no sample-and-hold is needed.

Encoding used throughout: `phase_o` is 0 while calibrating, 1 while converting, and 2 while holding. `cmp_i` high means the analog output is above the reference.

States and transitions:
- `ST_CAL_CLR` → `ST_CAL_INT` (always).
- `ST_CAL_INT` → `ST_CAL_SETTLE` when the 2^N window ends.
- `ST_CAL_SETTLE` → `ST_CAL_ADJ` after the synchronizer depth.
- `ST_CAL_ADJ` → `ST_HOLD` on convergence or the pass limit, otherwise → `ST_CAL_CLR`.
- `ST_HOLD` → `ST_CNV_CLR` on a valid code.
- `ST_CNV_CLR` → `ST_HOLD` for code zero, otherwise → `ST_CNV_INT`.
- `ST_CNV_INT` → `ST_HOLD` when the code-length window ends.

Top module: `dsdac_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `phase_o` is 0, `gain_o` equals GAIN_INIT, and `int_rst_o` and `freeze_o` are both 1.
- R2: Every calibration pass asserts `int_rst_o` for one cycle and then holds `freeze_o` low for exactly 2^N consecutive cycles. `freeze_o` only falls in the cycle right after `int_rst_o` was high.
- R3: Once per pass, after the freeze and a two-flop synchronizer delay, `gain_o` decreases by one when `cmp_i` is 1 and increases by one when it is 0. It never changes by more than one per cycle.
- R4: `gain_o` saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R5: Calibration stops after a pass whose direction differs from the previous pass, when that previous pass also reversed direction. The gain adjustment of that final pass is applied.
- R6: Calibration stops after MAX_PASSES passes even without convergence.
- R7: In hold, `phase_o` is 2, `freeze_o` is 1, `int_rst_o` is 0, and `gain_o` never changes outside calibration.
- R8: A `code_vld_i` seen in hold latches `code_i`. The controller gives one `int_rst_o` cycle with `phase_o` 1, then holds `freeze_o` low for exactly code·2^CONV_SHIFT cycles, then returns to hold.
- R9: A code of zero gives the clear pulse and returns to hold with no integration cycle.
- R10: `code_vld_i` during calibration or during a conversion is ignored: the integration length and the return to hold are unchanged.
- R11: `freeze_o` is 1 whenever `int_rst_o` is 1, and `phase_o` is never 2 while `freeze_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | CODE_W | Conversion code |
| code_vld_i | input | 1 | Code strobe, honoured only in hold |
| cmp_i | input | 1 | Comparator, 1 = output above reference (asynchronous) |
| gain_o | output | GAIN_W | Integrator gain trim code |
| int_rst_o | output | 1 | Integrator clear |
| freeze_o | output | 1 | Ground integrator input and hold output |
| phase_o | output | 2 | 0 calibrate, 1 convert, 2 hold |

## Verification
The hardest situations to reach are the two ways calibration ends: the double reversal, and the pass limit with the gain pinned at a rail. The bench drives the comparator from a virtual balance point, `cmp_i = (gain_o >= target)`. Placing the target above, below or beyond the gain range produces convergence from either side, saturation at the top, and saturation at the bottom. In each case the number of clear pulses and the final gain are predicted by an independent model of the trim rule.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;
    typedef enum logic [2:0] {
        ST_CAL_CLR,
        ST_CAL_INT,
        ST_CAL_SETTLE,
        ST_CAL_ADJ,
        ST_HOLD,
        ST_CNV_CLR,
        ST_CNV_INT
    } state_e;

    typedef enum logic [1:0] {
        PH_CAL  = 2'd0,
        PH_CNV  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;
endpackage

// File: rtl/dsdac_sync.sv
module dsdac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dsdac_timer.sv
module dsdac_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (en_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = en_i && (cnt_q == limit_i);
endmodule

// File: rtl/dsdac_gain_trim.sv
module dsdac_gain_trim #(
    parameter int GAIN_W     = 8,
    parameter int GAIN_INIT  = 128,
    parameter int MAX_PASSES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              down_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              done_o
);
    localparam int PC_W = $clog2(MAX_PASSES + 1);
    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};

    logic [GAIN_W-1:0] gain_q, gain_nxt;
    logic [PC_W-1:0]   pass_q;
    logic              seen_q, last_dn_q, last_rev_q;
    logic              rev;

    // a reversal needs a previous pass to compare with
    assign rev    = seen_q && (down_i != last_dn_q);
    assign done_o = step_i && ((rev && last_rev_q) ||
                               (pass_q == PC_W'(MAX_PASSES - 1)));

    always_comb begin
        if (down_i) gain_nxt = (gain_q == '0)  ? gain_q : gain_q - 1'b1;
        else        gain_nxt = (gain_q == GMAX) ? gain_q : gain_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q     <= GAIN_W'(GAIN_INIT);
            pass_q     <= '0;
            seen_q     <= 1'b0;
            last_dn_q  <= 1'b0;
            last_rev_q <= 1'b0;
        end else if (step_i) begin
            gain_q     <= gain_nxt;
            pass_q     <= pass_q + 1'b1;
            seen_q     <= 1'b1;
            last_dn_q  <= down_i;
            last_rev_q <= rev;
        end
    end

    assign gain_o = gain_q;
endmodule

// File: rtl/dsdac_ctrl.sv
module dsdac_ctrl
    import dsdac_pkg::*;
#(
    parameter int N           = 8,
    parameter int CODE_W      = 10,
    parameter int CONV_SHIFT  = 0,
    parameter int GAIN_W      = 8,
    parameter int GAIN_INIT   = 128,
    parameter int MAX_PASSES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              code_vld_i,
    input  logic              cmp_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              int_rst_o,
    output logic              freeze_o,
    output logic [1:0]        phase_o
);
    localparam int CAL_LEN = 2 ** N;
    localparam int LEN_W   = CODE_W + CONV_SHIFT;
    localparam int CNT_W   = ((N > LEN_W) ? N : LEN_W) + 1;

    state_e            state_q, state_nxt;
    logic [CODE_W-1:0] code_q;
    logic              cmp_s;
    logic              tmr_en, tmr_clr, tmr_last;
    logic [CNT_W-1:0]  tmr_limit, conv_len;
    logic              trim_step, trim_done;

    dsdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    dsdac_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .en_i    (tmr_en),
        .limit_i (tmr_limit),
        .last_o  (tmr_last)
    );

    dsdac_gain_trim #(
        .GAIN_W     (GAIN_W),
        .GAIN_INIT  (GAIN_INIT),
        .MAX_PASSES (MAX_PASSES)
    ) u_trim (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (trim_step),
        .down_i (cmp_s),
        .gain_o (gain_o),
        .done_o (trim_done)
    );

    assign conv_len = CNT_W'(code_q) << CONV_SHIFT;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CAL_CLR;
        else        state_q <= state_nxt;
    end

    // code latch, open only in hold
    always_ff @(posedge clk) begin
        if (!rst_n)                                 code_q <= '0;
        else if (state_q == ST_HOLD && code_vld_i) code_q <= code_i;
    end

    // next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_CAL_CLR:    state_nxt = ST_CAL_INT;
            ST_CAL_INT:    if (tmr_last) state_nxt = ST_CAL_SETTLE;
            ST_CAL_SETTLE: if (tmr_last) state_nxt = ST_CAL_ADJ;
            ST_CAL_ADJ:    state_nxt = trim_done ? ST_HOLD : ST_CAL_CLR;
            ST_HOLD:       if (code_vld_i) state_nxt = ST_CNV_CLR;
            ST_CNV_CLR:    state_nxt = (code_q == '0) ? ST_HOLD : ST_CNV_INT;
            ST_CNV_INT:    if (tmr_last) state_nxt = ST_HOLD;
            default:       state_nxt = ST_CAL_CLR;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        int_rst_o = 1'b0;
        freeze_o  = 1'b1;
        phase_o   = PH_CAL;
        tmr_en    = 1'b0;
        tmr_limit = '0;
        trim_step = 1'b0;
        unique case (state_q)
            ST_CAL_CLR: int_rst_o = 1'b1;
            ST_CAL_INT: begin
                freeze_o  = 1'b0;
                tmr_en    = 1'b1;
                tmr_limit = CNT_W'(CAL_LEN - 1);
            end
            ST_CAL_SETTLE: begin
                tmr_en    = 1'b1;
                tmr_limit = CNT_W'(SYNC_STAGES - 1);
            end
            ST_CAL_ADJ: trim_step = 1'b1;
            ST_HOLD:    phase_o   = PH_HOLD;
            ST_CNV_CLR: begin
                int_rst_o = 1'b1;
                phase_o   = PH_CNV;
            end
            ST_CNV_INT: begin
                freeze_o  = 1'b0;
                phase_o   = PH_CNV;
                tmr_en    = 1'b1;
                tmr_limit = conv_len - 1'b1;
            end
            default: int_rst_o = 1'b1;
        endcase
    end

    assign tmr_clr = !tmr_en || tmr_last;
endmodule

// File: rtl/dsdac_chk.sv
module dsdac_chk #(
    parameter int GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAIN_W-1:0] gain_o,
    input logic              int_rst_o,
    input logic              freeze_o,
    input logic [1:0]        phase_o
);
    localparam int GW1 = GAIN_W + 1;
    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};

    p_clear_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |-> freeze_o);

    p_no_hold_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_o |-> (phase_o != 2'd2));

    p_clear_before_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_o) |-> $past(int_rst_o));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o != $past(gain_o)) |->
            ((GW1'(gain_o) == GW1'($past(gain_o)) + 1'b1) ||
             (GW1'(gain_o) + 1'b1 == GW1'($past(gain_o)))));

    p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == GMAX) |=> (gain_o != '0));

    p_no_wrap_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == '0) |=> (gain_o != GMAX));

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |-> (freeze_o && !int_rst_o));

    p_gain_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |=> $stable(gain_o));
endmodule

bind dsdac_ctrl dsdac_chk #(.GAIN_W(GAIN_W)) u_dsdac_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gain_o    (gain_o),
    .int_rst_o (int_rst_o),
    .freeze_o  (freeze_o),
    .phase_o   (phase_o)
);

// File: tb/test_dsdac_ctrl.sv
module test_dsdac_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;
    localparam int CODE_W     = 5;
    localparam int CONV_SHIFT = 1;
    localparam int GAIN_W     = 6;
    localparam int GAIN_INIT  = 32;
    localparam int MAX_PASSES = 64;
    localparam int GMAX       = 2 ** GAIN_W - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic              code_vld = 1'b0;
    logic              cmp;
    logic [GAIN_W-1:0] gain;
    logic              int_rst, freeze;
    logic [1:0]        phase;
    int                target = 0;

    typedef struct {
        int    gain;
        int    frz;
        int    rsts;
        string req;
    } exp_t;
    exp_t sb_q[$];

    int checks = 0;
    int errors = 0;
    int exp_gain = GAIN_INIT;
    int frz_cnt = 0;
    int rst_cnt = 0;
    int prev_ph = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // comparator modelled from a virtual balance point
    assign cmp = (int'(gain) >= target);

    dsdac_ctrl #(
        .N(N), .CODE_W(CODE_W), .CONV_SHIFT(CONV_SHIFT), .GAIN_W(GAIN_W),
        .GAIN_INIT(GAIN_INIT), .MAX_PASSES(MAX_PASSES), .SYNC_STAGES(2)
    ) i_dsdac_ctrl (
        .clk(clk), .rst_n(rst_n), .code_i(code), .code_vld_i(code_vld),
        .cmp_i(cmp), .gain_o(gain), .int_rst_o(int_rst), .freeze_o(freeze),
        .phase_o(phase)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void cal_model(int tgt, output int g, output int n);
        int last_dn = 0;
        int seen = 0;
        int last_rev = 0;
        g = GAIN_INIT;
        n = 0;
        while (1) begin
            int dn;
            int rev;
            int conv;
            dn   = (g >= tgt) ? 1 : 0;
            rev  = (seen != 0 && dn != last_dn) ? 1 : 0;
            conv = (rev != 0 && last_rev != 0) ? 1 : 0;
            if (dn != 0) g = (g == 0) ? 0 : g - 1;
            else         g = (g == GMAX) ? GMAX : g + 1;
            n++;
            seen = 1;
            last_dn = dn;
            last_rev = rev;
            if (conv != 0 || n == MAX_PASSES) break;
        end
    endfunction

    // monitor: measures each integration and pops on every return to hold
    always @(negedge clk) begin
        if (!rst_n) begin
            frz_cnt = 0;
            rst_cnt = 0;
            prev_ph = 0;
        end else begin
            if (int_rst) begin
                rst_cnt++;
                frz_cnt = 0;
            end
            if (!freeze) frz_cnt++;
            if (phase == 2'd2 && prev_ph != 2) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected hold entry", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(gain) == e.gain, e.req, "gain at hold", int'(gain), e.gain);
                    check(frz_cnt == e.frz, e.req, "integration cycles", frz_cnt, e.frz);
                    check(rst_cnt == e.rsts, e.req, "clear pulses", rst_cnt, e.rsts);
                end
                rst_cnt = 0;
            end
            prev_ph = int'(phase);
        end
    end

    task automatic wait_drained();
        while (sb_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic run_cal(int tgt, string req, bit poke);
        int g;
        int n;
        exp_t e;
        target = tgt;
        cal_model(tgt, g, n);
        exp_gain = g;
        e.gain = g;
        e.frz  = 2 ** N;
        e.rsts = n;
        e.req  = req;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(phase == 2'd0, "R1", "phase in reset", int'(phase), 0);
        check(int'(gain) == GAIN_INIT, "R1", "gain in reset", int'(gain), GAIN_INIT);
        sb_q.push_back(e);
        rst_n = 1'b1;
        @(negedge clk);
        check(int_rst && freeze, "R1", "clear+freeze after reset",
              int'({int_rst, freeze}), 3);
        check(phase == 2'd0, "R1", "phase after reset", int'(phase), 0);
        if (poke) begin
            // R10: strobe during calibration must not start anything
            repeat (3) @(posedge clk);
            #1;
            code = 5'd7;
            code_vld = 1'b1;
            @(posedge clk);
            #1;
            code_vld = 1'b0;
        end
        wait_drained();
        repeat (4) @(negedge clk);
        check(phase == 2'd2 && freeze, "R10", "still holding after cal strobe",
              int'(phase), 2);
        check(int'(gain) == exp_gain, "R7", "gain held", int'(gain), exp_gain);
    endtask

    task automatic run_conv(int c, bit poke);
        exp_t e;
        e.gain = exp_gain;
        e.frz  = c << CONV_SHIFT;
        e.rsts = 1;
        e.req  = (c == 0) ? "R9" : "R8";
        sb_q.push_back(e);
        @(posedge clk);
        #1;
        code = CODE_W'(c);
        code_vld = 1'b1;
        @(posedge clk);
        #1;
        code_vld = 1'b0;
        @(negedge clk);
        check(phase == 2'd1 && int_rst, "R8", "clear pulse in convert phase",
              int'(phase), 1);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            check(phase == 2'd1 && !freeze, "R8", "integrating", int'(freeze), 0);
            // R10: strobe during conversion is ignored
            code = 5'd3;
            code_vld = 1'b1;
            @(posedge clk);
            #1;
            code_vld = 1'b0;
        end
        wait_drained();
        repeat (3) @(negedge clk);
        check(phase == 2'd2, "R10", "hold after conversion", int'(phase), 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_cal(40, "R5", 1'b1);      // converge from below
        run_conv(13, 1'b1);
        run_conv(0, 1'b0);            // R9
        run_conv(31, 1'b0);
        run_conv(1, 1'b0);
        run_cal(20, "R5", 1'b0);      // converge from above, R3 direction
        run_conv(5, 1'b1);
        run_cal(100, "R6", 1'b0);     // pinned at top: R4 and R6
        check(int'(gain) == GMAX, "R4", "top rail", int'(gain), GMAX);
        run_conv(2, 1'b0);
        run_cal(0, "R6", 1'b0);       // pinned at bottom: R4 and R6
        check(int'(gain) == 0, "R4", "bottom rail", int'(gain), 0);
        run_conv(0, 1'b0);
        check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule